// File: doc/BRIEF.md
# Reset and Wake Cause Tracker

This block keeps two status flags that let software work out, after the fact, why the core last restarted or woke. The time-out flag (T) and the power-down flag (P) each take a pattern that depends on the event and on whether the core was running or sleeping when it arrived. Some events also keep the flag values they found.

The block follows the core's run/sleep state, which changes on a sleep-entry strobe from the instruction decoder. It sorts incoming events into two groups. Sources in the first group restart the program from the reset vector, and the block asks for that with a one-cycle reset request. Sources in the second group let execution continue after the sleep instruction, and the block asks for that with a one-cycle resume request.

The power-on pulse is an asynchronous reset of the whole block. The active-low external reset pin is asynchronous, so it passes through a synchronizer of `SYNC_STAGES` flops before it takes effect. All other inputs are single-cycle strobes that are synchronous to `clk`. The block has no data stream, so every pin is a plain control or status signal.

Top module: `rst_cause_tracker`

## Requirements
- R1: While `por` is high, and in the first cycle after it falls, `flag_t`=1, `flag_p`=1, the core is running, and both requests are 0. `por` overrides every other input.
- R2: A falling edge on `ext_rst_n` while the core runs keeps `flag_t` and `flag_p` unchanged and raises `core_rst_req` for exactly one cycle, however long the pin stays low.
- R3: A falling edge on `ext_rst_n` while the core sleeps gives `flag_t`=1 and `flag_p`=0, returns the core to running, and raises `core_rst_req` for one cycle.
- R4: `wdt_timeout` with `wdt_en`=1 while the core runs clears `flag_t`, keeps `flag_p`, and raises `core_rst_req` for one cycle.
- R5: `wdt_timeout` with `wdt_en`=1 while the core sleeps gives `flag_t`=0 and `flag_p`=0, returns the core to running, and raises `core_rst_req`.
- R6: `wdt_timeout` has no effect while `wdt_en`=0.
- R7: `pin_wake` with `pin_wake_en`=1 while the core sleeps gives `flag_t`=1 and `flag_p`=0, returns the core to running, and raises `resume_req` for one cycle with no reset request. `pin_wake` is ignored while `pin_wake_en`=0 or while the core runs.
- R8: `cmp_wake` while the core sleeps acts as in R7 and raises `resume_req`.
- R9: `sleep_enter` while the core runs gives `flag_t`=1 and `flag_p`=0 and puts the core to sleep. While the core sleeps, `sleep_enter` and `wdt_clear` are ignored.
- R10: `wdt_clear` while the core runs sets `flag_t`=1 and `flag_p`=1.
- R11: Priority, from highest to lowest: external reset, then watchdog time-out, then wake strobes, then `sleep_enter`, then `wdt_clear`. While the synchronized `ext_rst_n` stays low, every other strobe is ignored.
- R12: Flags and requests change at the clock edge after the event. An external reset takes effect `SYNC_STAGES`+1 edges after the pin falls. `core_rst_req` and `resume_req` never stay high for two cycles in a row and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on pulse, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_en | input | 1 | Watchdog enable |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| pin_wake_en | input | 1 | Enables wake on a port pin change |
| pin_wake | input | 1 | Port pin-change strobe |
| cmp_wake | input | 1 | Comparator went high (wake strobe) |
| sleep_enter | input | 1 | Sleep instruction executed |
| wdt_clear | input | 1 | Watchdog-clear instruction executed |
| flag_t | output | 1 | Time-out status flag |
| flag_p | output | 1 | Power-down status flag |
| core_rst_req | output | 1 | One-cycle request to restart the core |
| resume_req | output | 1 | One-cycle request to continue after sleep |

## Verification
Each source is applied once with the core running and once with it sleeping. The T/P patterns then show whether the block tells the two modes apart, and whether it keeps old flag values where it should rather than forcing them. Disabled and out-of-mode strobes check that gating works. Simultaneous pairs of strobes, together with an external reset that is held low, show the priority order and the single reset pulse. A behavioural model then checks every cycle against the outputs.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_EXT_HOLD,
    EV_EXT,
    EV_WDT,
    EV_WAKE,
    EV_SLEEP,
    EV_CLEAR
  } rwt_ev_e;

  typedef struct packed {
    logic t;
    logic p;
  } rwt_flags_t;

  localparam rwt_flags_t FLAGS_POR   = '{t: 1'b1, p: 1'b1};
  localparam rwt_flags_t FLAGS_SLEPT = '{t: 1'b1, p: 1'b0};
endpackage

// File: rtl/rwt_pin_sync.sv
module rwt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic pin_n,
  output logic pin_sync_n
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge por) begin
        if (por) chain <= '1;
        else     chain <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge por) begin
        if (por) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign pin_sync_n = chain[STAGES-1];
endmodule

// File: rtl/rwt_event_sel.sv
module rwt_event_sel
  import rwt_pkg::*;
(
  input  logic    ext_low,
  input  logic    ext_first,
  input  logic    asleep,
  input  logic    wdt_en,
  input  logic    wdt_timeout,
  input  logic    pin_wake_en,
  input  logic    pin_wake,
  input  logic    cmp_wake,
  input  logic    sleep_enter,
  input  logic    wdt_clear,
  output rwt_ev_e ev
);
  logic wake_hit;
  assign wake_hit = (pin_wake && pin_wake_en) || cmp_wake;

  always_comb begin
    ev = EV_NONE;
    if (ext_low)                      ev = ext_first ? EV_EXT : EV_EXT_HOLD;
    else if (wdt_timeout && wdt_en)   ev = EV_WDT;
    else if (asleep && wake_hit)      ev = EV_WAKE;
    else if (!asleep && sleep_enter)  ev = EV_SLEEP;
    else if (!asleep && wdt_clear)    ev = EV_CLEAR;
  end

  // R11: a low external reset always hides the other sources
  always_comb begin
    if (ext_low) begin
      a_r11_ext_dominates: assert (ev == EV_EXT || ev == EV_EXT_HOLD);
    end
  end
endmodule

// File: rtl/rwt_state.sv
module rwt_state
  import rwt_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  rwt_ev_e    ev,
  input  logic       ext_level_n,
  output logic       ext_prev_n,
  output logic       asleep,
  output rwt_flags_t flags,
  output logic       rst_req,
  output logic       resume_req
);
  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      asleep     <= 1'b0;
      flags      <= FLAGS_POR;
      rst_req    <= 1'b0;
      resume_req <= 1'b0;
      ext_prev_n <= 1'b1;
    end else begin
      ext_prev_n <= ext_level_n;
      rst_req    <= 1'b0;
      resume_req <= 1'b0;
      case (ev)
        EV_EXT: begin
          rst_req <= 1'b1;
          asleep  <= 1'b0;
          if (asleep) flags <= FLAGS_SLEPT;
        end
        EV_WDT: begin
          rst_req <= 1'b1;
          asleep  <= 1'b0;
          flags.t <= 1'b0;
          if (asleep) flags.p <= 1'b0;
        end
        EV_WAKE: begin
          resume_req <= 1'b1;
          asleep     <= 1'b0;
          flags      <= FLAGS_SLEPT;
        end
        EV_SLEEP: begin
          asleep <= 1'b1;
          flags  <= FLAGS_SLEPT;
        end
        EV_CLEAR: flags <= FLAGS_POR;
        default: ;
      endcase
    end
  end

  // R1: flags read 1/1 while power-on is applied
  always @(negedge clk) begin
    if (por) a_r1_por_flags: assert (flags.t && flags.p);
  end

  a_r2_ext_run_keeps: assert property (@(posedge clk) disable iff (por)
    (ev == EV_EXT && !asleep) |=> ($stable(flags) && rst_req));
  a_r3_ext_sleep: assert property (@(posedge clk) disable iff (por)
    (ev == EV_EXT && asleep) |=> (flags.t && !flags.p && !asleep));
  a_r4_wdt_run: assert property (@(posedge clk) disable iff (por)
    (ev == EV_WDT && !asleep) |=> (!flags.t && flags.p == $past(flags.p)));
  a_r5_wdt_sleep: assert property (@(posedge clk) disable iff (por)
    (ev == EV_WDT && asleep) |=> (!flags.t && !flags.p && rst_req && !asleep));
  a_r7_resume_origin: assert property (@(posedge clk) disable iff (por)
    resume_req |-> (!asleep && $past(asleep)));
  a_r9_sleep_entry: assert property (@(posedge clk) disable iff (por)
    (ev == EV_SLEEP) |=> (asleep && flags.t && !flags.p));
  a_r12_rst_single: assert property (@(posedge clk) disable iff (por)
    rst_req |=> !rst_req);
  a_r12_res_single: assert property (@(posedge clk) disable iff (por)
    resume_req |=> !resume_req);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (por)
    !(rst_req && resume_req));
endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rwt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic ext_rst_n,
  input  logic wdt_en,
  input  logic wdt_timeout,
  input  logic pin_wake_en,
  input  logic pin_wake,
  input  logic cmp_wake,
  input  logic sleep_enter,
  input  logic wdt_clear,
  output logic flag_t,
  output logic flag_p,
  output logic core_rst_req,
  output logic resume_req
);
  logic       ext_sync_n;
  logic       ext_prev_n;
  logic       asleep;
  rwt_ev_e    ev;
  rwt_flags_t flags;

  rwt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .por        (por),
    .pin_n      (ext_rst_n),
    .pin_sync_n (ext_sync_n)
  );

  rwt_event_sel u_sel (
    .ext_low     (!ext_sync_n),
    .ext_first   (ext_prev_n),
    .asleep      (asleep),
    .wdt_en      (wdt_en),
    .wdt_timeout (wdt_timeout),
    .pin_wake_en (pin_wake_en),
    .pin_wake    (pin_wake),
    .cmp_wake    (cmp_wake),
    .sleep_enter (sleep_enter),
    .wdt_clear   (wdt_clear),
    .ev          (ev)
  );

  rwt_state u_state (
    .clk         (clk),
    .por         (por),
    .ev          (ev),
    .ext_level_n (ext_sync_n),
    .ext_prev_n  (ext_prev_n),
    .asleep      (asleep),
    .flags       (flags),
    .rst_req     (core_rst_req),
    .resume_req  (resume_req)
  );

  assign flag_t = flags.t;
  assign flag_p = flags.p;

  // R2: a held-low pin gives no second request
  a_r2_one_req_per_edge: assert property (@(posedge clk) disable iff (por)
    (!ext_sync_n && !ext_prev_n) |=> !core_rst_req);
endmodule

// File: tb/sim_rst_cause_tracker.sv
module sim_rst_cause_tracker;
  localparam int S = 2;

  logic clk = 1'b0;
  logic por = 1'b1, ext_rst_n = 1'b1, wdt_en = 1'b0, wdt_timeout = 1'b0;
  logic pin_wake_en = 1'b0, pin_wake = 1'b0, cmp_wake = 1'b0;
  logic sleep_enter = 1'b0, wdt_clear = 1'b0;
  logic flag_t, flag_p, core_rst_req, resume_req;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_cause_tracker #(.SYNC_STAGES(S)) u0 (
    .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .wdt_en(wdt_en),
    .wdt_timeout(wdt_timeout), .pin_wake_en(pin_wake_en), .pin_wake(pin_wake),
    .cmp_wake(cmp_wake), .sleep_enter(sleep_enter), .wdt_clear(wdt_clear),
    .flag_t(flag_t), .flag_p(flag_p), .core_rst_req(core_rst_req),
    .resume_req(resume_req)
  );

  // Behavioural reference model
  int m_t = 1, m_p = 1, m_sl = 0, m_rst = 0, m_res = 0, m_prev = 1;
  int m_pipe[S];

  always @(posedge clk) begin
    if (por) begin
      m_t = 1; m_p = 1; m_sl = 0; m_rst = 0; m_res = 0; m_prev = 1;
      foreach (m_pipe[i]) m_pipe[i] = 1;
    end else begin
      int n_rst, n_res;
      n_rst = 0; n_res = 0;
      if (m_pipe[S-1] == 0) begin
        if (m_prev == 1) begin
          n_rst = 1;
          if (m_sl != 0) begin m_t = 1; m_p = 0; end
          m_sl = 0;
        end
      end else if (wdt_timeout && wdt_en) begin
        m_t = 0;
        if (m_sl != 0) m_p = 0;
        m_sl = 0; n_rst = 1;
      end else if (m_sl != 0 && ((pin_wake && pin_wake_en) || cmp_wake)) begin
        m_t = 1; m_p = 0; m_sl = 0; n_res = 1;
      end else if (m_sl == 0 && sleep_enter) begin
        m_t = 1; m_p = 0; m_sl = 1;
      end else if (m_sl == 0 && wdt_clear) begin
        m_t = 1; m_p = 1;
      end
      m_prev = m_pipe[S-1];
      for (int i = S-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = int'(ext_rst_n);
      m_rst = n_rst; m_res = n_res;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R12: cycle-by-cycle comparison with the model
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("R12 model flag_t", int'(flag_t), m_t);
      chk("R12 model flag_p", int'(flag_p), m_p);
      chk("R12 model core_rst_req", int'(core_rst_req), m_rst);
      chk("R12 model resume_req", int'(resume_req), m_res);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) cyc();
    chk("R1 t during por", int'(flag_t), 1);
    chk("R1 p during por", int'(flag_p), 1);
    por = 0; cyc();
    chk("R1 t after por", int'(flag_t), 1);
    chk("R1 rst after por", int'(core_rst_req), 0);

    // R4: watchdog while running
    wdt_en = 1; wdt_timeout = 1; cyc(); wdt_timeout = 0;
    chk("R4 t", int'(flag_t), 0);
    chk("R4 p kept", int'(flag_p), 1);
    chk("R4 rst", int'(core_rst_req), 1);
    cyc();
    chk("R12 rst single", int'(core_rst_req), 0);

    // R2: external reset while running, held low
    ext_rst_n = 0; n = 0;
    repeat (6) begin cyc(); if (core_rst_req) n++; end
    ext_rst_n = 1;
    chk("R2 one pulse", n, 1);
    chk("R2 t kept", int'(flag_t), 0);
    chk("R2 p kept", int'(flag_p), 1);
    repeat (3) cyc();

    // R10: watchdog clear
    wdt_clear = 1; cyc(); wdt_clear = 0;
    chk("R10 t", int'(flag_t), 1);
    chk("R10 p", int'(flag_p), 1);

    // R9: sleep entry, clear ignored while asleep
    sleep_enter = 1; cyc(); sleep_enter = 0;
    chk("R9 t", int'(flag_t), 1);
    chk("R9 p", int'(flag_p), 0);
    wdt_clear = 1; cyc(); wdt_clear = 0;
    chk("R9 clear ignored asleep", int'(flag_p), 0);

    // R7: disabled pin wake, then enabled
    pin_wake_en = 0; pin_wake = 1; cyc(); pin_wake = 0;
    chk("R7 disabled no resume", int'(resume_req), 0);
    pin_wake_en = 1; pin_wake = 1; cyc(); pin_wake = 0;
    chk("R7 resume", int'(resume_req), 1);
    chk("R7 no rst", int'(core_rst_req), 0);
    chk("R7 p", int'(flag_p), 0);
    cyc();
    chk("R12 resume single", int'(resume_req), 0);
    wdt_clear = 1; cyc(); wdt_clear = 0;
    chk("R7 running again", int'(flag_p), 1);
    pin_wake = 1; cyc(); pin_wake = 0;
    chk("R7 ignored running", int'(resume_req), 0);

    // R8: comparator wake
    sleep_enter = 1; cyc(); sleep_enter = 0;
    cmp_wake = 1; cyc(); cmp_wake = 0;
    chk("R8 resume", int'(resume_req), 1);
    chk("R8 t", int'(flag_t), 1);

    // R5: watchdog while sleeping
    sleep_enter = 1; cyc(); sleep_enter = 0;
    wdt_timeout = 1; cyc(); wdt_timeout = 0;
    chk("R5 t", int'(flag_t), 0);
    chk("R5 p", int'(flag_p), 0);
    chk("R5 rst", int'(core_rst_req), 1);

    // R6: disabled watchdog
    wdt_clear = 1; cyc(); wdt_clear = 0;
    wdt_en = 0; wdt_timeout = 1; cyc(); wdt_timeout = 0;
    chk("R6 t unchanged", int'(flag_t), 1);
    chk("R6 no rst", int'(core_rst_req), 0);
    wdt_en = 1;

    // R3: external reset during sleep
    sleep_enter = 1; cyc(); sleep_enter = 0;
    ext_rst_n = 0; n = 0;
    repeat (5) begin cyc(); if (core_rst_req) n++; end
    ext_rst_n = 1;
    chk("R3 one pulse", n, 1);
    chk("R3 t", int'(flag_t), 1);
    chk("R3 p", int'(flag_p), 0);
    repeat (3) cyc();
    wdt_clear = 1; cyc(); wdt_clear = 0;
    chk("R3 running after", int'(flag_p), 1);

    // R11: watchdog beats wake
    sleep_enter = 1; cyc(); sleep_enter = 0;
    wdt_timeout = 1; pin_wake = 1; cyc(); wdt_timeout = 0; pin_wake = 0;
    chk("R11 wdt over wake t", int'(flag_t), 0);
    chk("R11 wdt over wake res", int'(resume_req), 0);

    // R11: sleep beats clear
    wdt_clear = 1; cyc(); wdt_clear = 0;
    sleep_enter = 1; wdt_clear = 1; cyc(); sleep_enter = 0; wdt_clear = 0;
    chk("R11 sleep over clear", int'(flag_p), 0);

    // R11: external reset beats watchdog (core asleep)
    ext_rst_n = 0; cyc(); cyc();
    wdt_timeout = 1; cyc(); wdt_timeout = 0;
    chk("R11 ext over wdt rst", int'(core_rst_req), 1);
    chk("R11 ext over wdt t", int'(flag_t), 1);
    repeat (3) cyc(); ext_rst_n = 1; repeat (3) cyc();

    // R11: held reset suppresses sleep
    wdt_clear = 1; cyc(); wdt_clear = 0;
    ext_rst_n = 0; repeat (4) cyc();
    sleep_enter = 1; cyc(); sleep_enter = 0;
    chk("R11 hold blocks sleep", int'(flag_p), 1);
    ext_rst_n = 1; repeat (3) cyc();
    pin_wake = 1; cyc(); pin_wake = 0;
    chk("R11 still running", int'(resume_req), 0);

    // R1: power-on overrides a watchdog strobe
    wdt_timeout = 1; por = 1; cyc();
    chk("R1 por wins t", int'(flag_t), 1);
    chk("R1 por wins rst", int'(core_rst_req), 0);
    por = 0; wdt_timeout = 0; repeat (2) cyc();

    finish_run();
  end
endmodule